// File: doc/BRIEF.md
# Multi-Bus Golden-Reference Stream Monitor

This block sits at the outputs of a device under test that drives several parallel sample streams. Each stream has its own checker. The checker steps through a reference table, one table word per accepted beat, and compares each beat against that word. The table index wraps at the iteration length, so repeated iterations stay aligned. Each checker counts every accepted beat and every mismatch. It also measures two timing figures:

- the delay from the start of an iteration at the stimulus side to the first output beat of that iteration;
- the number of beats seen in a fixed window of clock cycles.

One small register port serves all checkers. A select field in the control word chooses which stream's statistics are returned on reads. The wide counters are read in two halves: reading the low half captures the matching high half, so a read pair gives one coherent value. A test run starts on the rising edge of the test-on level. That edge clears all statistics. While the level is low, stream traffic is ignored.

Top module: `stream_golden_monitor`

## Requirements
- R1: The reference word for stream b at table index i is {8-bit (b+1), 24-bit (5*i+1)}. Each accepted beat is compared with the word at the stream's running index. The index starts at 0, advances by one per accepted beat, and wraps to 0 after ITER_LEN-1 (default 16).
- R2: A beat is accepted when its valid bit is high while test_on is high, except on the cycle test_on rises. Each accepted beat adds one to the stream's 64-bit output count. Beats while test_on is low change nothing.
- R3: An accepted beat whose data differs from its reference word adds one to the stream's 64-bit mismatch count.
- R4: The low halves of the output count and the mismatch count are read at addresses 1 and 3. A low-half read latches the high half of the same counter, of the selected stream, into a shadow. That shadow is returned at address 2 (output count) or 4 (mismatch count).
- R5: An iter_start pulse sampled at clock edge T arms the latency measurement. The first later accepted beat with index 0, sampled at edge T+L, yields latency L. The first such latency after a run start is kept at address 5 (first-run latency).
- R6: Every later latency updates a minimum at address 6 and a maximum at address 7. Both read 0 until the first of those later latencies.
- R7: Address 8 returns the number of accepted beats in the last completed window of WIN_CYC cycles (default 64). The window timer restarts at run start.
- R8: Writing address 0 sets the stream select from data bits [1:0]. Reading address 0 returns the select, zero-extended. Other fields and addresses read 0.
- R9: A read sampled at edge T presents its data on reg_rdata after edge T and holds it until the next read.
- R10: A rising edge of test_on clears all counts, latencies, the throughput figure and the table index of every stream. The stream select is kept.
- R11: After reset every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream-side clock |
| rst | input | 1 | Synchronous active-high reset |
| test_on | input | 1 | Test run level; its rising edge starts a run |
| iter_start | input | 1 | Pulse when the first input beat of an iteration is accepted |
| mon_valid | input | NUM_BUS | Per-stream beat valid |
| mon_data | input | NUM_BUS*32 | Per-stream beat data, stream b in bits [32b+31:32b] |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the read strobe |

## Verification
Every statistic reaches the register port only through a read. The read result appears one edge after the read strobe is sampled, so the scoreboard compares on the falling edge that follows that strobe. The bench places each stream's output beats a chosen number of cycles after the sampled iter_start edge, which sets the expected latency in cycles directly. Mismatches are injected at chosen table indices. Throughput is checked with stream patterns whose periods divide the window, so every complete window holds a known count whatever its alignment. Each throughput read is made only after at least two full windows of that pattern.

// File: rtl/smon_pkg.sv
package smon_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned SEL_W  = 2;
    localparam int unsigned CNT_W  = 64;
    localparam int unsigned LAT_W  = 16;
    localparam int unsigned ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL      = 4'd0,
        RA_OUT_LO    = 4'd1,
        RA_OUT_HI    = 4'd2,
        RA_ERR_LO    = 4'd3,
        RA_ERR_HI    = 4'd4,
        RA_LAT_FIRST = 4'd5,
        RA_LAT_MIN   = 4'd6,
        RA_LAT_MAX   = 4'd7,
        RA_THRU      = 4'd8
    } reg_addr_e;

    typedef struct packed {
        logic [CNT_W-1:0]  outs;
        logic [CNT_W-1:0]  errs;
        logic [LAT_W-1:0]  lat_first;
        logic [LAT_W-1:0]  lat_min;
        logic [LAT_W-1:0]  lat_max;
        logic [WORD_W-1:0] thru;
    } stream_stats_t;

    // Reference word: stream tag in the top byte, index pattern below.
    function automatic logic [WORD_W-1:0] ref_word(input int unsigned bus,
                                                    input int unsigned idx);
        logic [23:0] body;
        body = 24'(idx * 5 + 1);
        return {8'(bus + 1), body};
    endfunction

endpackage

// File: rtl/golden_rom.sv
module golden_rom
    import smon_pkg::*;
#(
    parameter int unsigned BUS_ID   = 0,
    parameter int unsigned ITER_LEN = 16
) (
    input  logic [$clog2(ITER_LEN)-1:0] addr,
    output logic [WORD_W-1:0]           word
);

    logic [WORD_W-1:0] table_w [ITER_LEN];

    for (genvar i = 0; i < ITER_LEN; i++) begin : g_entry
        assign table_w[i] = ref_word(BUS_ID, i);
    end

    assign word = table_w[addr];

endmodule

// File: rtl/window_timer.sv
module window_timer #(
    parameter int unsigned WIN_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic win_end
);

    localparam int unsigned CW = $clog2(WIN_CYC);
    localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

    logic [CW-1:0] wcnt;

    assign win_end = run && (wcnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wcnt <= '0;
        end else if (run) begin
            wcnt <= (wcnt == LAST) ? '0 : wcnt + 1'b1;
        end
    end

    // R7
    win_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        win_end |=> (wcnt == '0));

endmodule

// File: rtl/bus_checker.sv
module bus_checker
    import smon_pkg::*;
#(
    parameter int unsigned BUS_ID   = 0,
    parameter int unsigned ITER_LEN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              active,
    input  logic              iter_start,
    input  logic              win_end,
    input  logic              beat_valid,
    input  logic [WORD_W-1:0] beat_data,
    output stream_stats_t     stats
);

    localparam int unsigned IDX_W = $clog2(ITER_LEN);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ITER_LEN - 1);

    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] ref_data;
    logic              beat, mism, cap;
    logic              arm, first_seen, later_seen;
    logic [LAT_W-1:0]  lat_cnt;
    logic [WORD_W-1:0] acc;

    golden_rom #(.BUS_ID(BUS_ID), .ITER_LEN(ITER_LEN)) u_rom (
        .addr (idx),
        .word (ref_data)
    );

    assign beat = active && beat_valid;
    assign mism = beat && (beat_data != ref_data);
    assign cap  = beat && arm && (idx == '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx              <= '0;
            stats            <= '0;
            arm              <= 1'b0;
            lat_cnt          <= '0;
            first_seen       <= 1'b0;
            later_seen       <= 1'b0;
            acc              <= '0;
        end else begin
            if (beat) begin
                idx        <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
                stats.outs <= stats.outs + 1'b1;
            end
            if (mism) begin
                stats.errs <= stats.errs + 1'b1;
            end
            if (cap) begin
                if (!first_seen) begin
                    stats.lat_first <= lat_cnt;
                    first_seen      <= 1'b1;
                end else if (!later_seen) begin
                    stats.lat_min <= lat_cnt;
                    stats.lat_max <= lat_cnt;
                    later_seen    <= 1'b1;
                end else begin
                    if (lat_cnt < stats.lat_min) stats.lat_min <= lat_cnt;
                    if (lat_cnt > stats.lat_max) stats.lat_max <= lat_cnt;
                end
            end
            if (iter_start && active) begin
                arm     <= 1'b1;
                lat_cnt <= LAT_W'(1);
            end else begin
                if (cap) arm <= 1'b0;
                if (arm && (lat_cnt != '1)) lat_cnt <= lat_cnt + 1'b1;
            end
            if (win_end) begin
                stats.thru <= acc + WORD_W'(beat);
                acc        <= '0;
            end else begin
                acc <= acc + WORD_W'(beat);
            end
        end
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && !clear) |=> $stable(stats.outs) && $stable(stats.errs));

    // R3
    err_bound_chk: assert property (@(posedge clk) disable iff (rst)
        stats.errs <= stats.outs);

    // R6
    lat_order_chk: assert property (@(posedge clk) disable iff (rst)
        later_seen |-> (stats.lat_min <= stats.lat_max));

    // R10
    run_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (stats.outs == '0) && (stats.errs == '0) && (stats.thru == '0));

endmodule

// File: rtl/stream_golden_monitor.sv
module stream_golden_monitor
    import smon_pkg::*;
#(
    parameter int unsigned NUM_BUS  = 4,
    parameter int unsigned ITER_LEN = 16,
    parameter int unsigned WIN_CYC  = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      test_on,
    input  logic                      iter_start,
    input  logic [NUM_BUS-1:0]        mon_valid,
    input  logic [NUM_BUS*WORD_W-1:0] mon_data,
    input  logic                      reg_wr,
    input  logic                      reg_rd,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [WORD_W-1:0]         reg_wdata,
    output logic [WORD_W-1:0]         reg_rdata
);

    localparam int unsigned HALF = CNT_W / 2;

    logic              run_q, run_rise, active, win_end;
    logic [SEL_W-1:0]  sel_q;
    logic [HALF-1:0]   out_hi_q, err_hi_q;
    logic [WORD_W-1:0] rd_word;
    stream_stats_t     st_arr [NUM_BUS];
    stream_stats_t     cur;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata[WORD_W-1:SEL_W];
    assign run_rise     = test_on && !run_q;
    assign active       = test_on && !run_rise;

    window_timer #(.WIN_CYC(WIN_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (run_rise),
        .run     (active),
        .win_end (win_end)
    );

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        bus_checker #(.BUS_ID(b), .ITER_LEN(ITER_LEN)) u_chk (
            .clk        (clk),
            .rst        (rst),
            .clear      (run_rise),
            .active     (active),
            .iter_start (iter_start),
            .win_end    (win_end),
            .beat_valid (mon_valid[b]),
            .beat_data  (mon_data[b*WORD_W +: WORD_W]),
            .stats      (st_arr[b])
        );
    end

    assign cur = st_arr[sel_q];

    always_comb begin
        case (reg_addr)
            RA_CTRL:      rd_word = WORD_W'(sel_q);
            RA_OUT_LO:    rd_word = cur.outs[HALF-1:0];
            RA_OUT_HI:    rd_word = out_hi_q;
            RA_ERR_LO:    rd_word = cur.errs[HALF-1:0];
            RA_ERR_HI:    rd_word = err_hi_q;
            RA_LAT_FIRST: rd_word = WORD_W'(cur.lat_first);
            RA_LAT_MIN:   rd_word = WORD_W'(cur.lat_min);
            RA_LAT_MAX:   rd_word = WORD_W'(cur.lat_max);
            RA_THRU:      rd_word = cur.thru;
            default:      rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= 1'b0;
            sel_q     <= '0;
            out_hi_q  <= '0;
            err_hi_q  <= '0;
            reg_rdata <= '0;
        end else begin
            run_q <= test_on;
            if (reg_wr && (reg_addr == RA_CTRL)) begin
                sel_q <= reg_wdata[SEL_W-1:0];
            end
            if (reg_rd) begin
                reg_rdata <= rd_word;
                if (reg_addr == RA_OUT_LO) out_hi_q <= cur.outs[CNT_W-1:HALF];
                if (reg_addr == RA_ERR_LO) err_hi_q <= cur.errs[CNT_W-1:HALF];
            end
        end
    end

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> $stable(reg_rdata));

    // R8
    sel_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && (reg_addr == RA_CTRL)) |=> $stable(sel_q));

endmodule

// File: tb/stream_golden_monitor_tb.sv
`timescale 1ns/1ps
module stream_golden_monitor_tb;

    localparam int NB = 4;
    localparam int IL = 16;
    localparam int W  = 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            test_on = 1'b0;
    logic            iter_start = 1'b0;
    logic [NB-1:0]   mon_valid = '0;
    logic [NB*32-1:0] mon_data = '0;
    logic            reg_wr = 1'b0;
    logic            reg_rd = 1'b0;
    logic [3:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_pend = 1'b0;
    logic        done = 1'b0;

    always #2 clk = ~clk;

    stream_golden_monitor #(.NUM_BUS(NB), .ITER_LEN(IL), .WIN_CYC(W)) u_dut (
        .clk(clk), .rst(rst), .test_on(test_on), .iter_start(iter_start),
        .mon_valid(mon_valid), .mon_data(mon_data),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [31:0] ref_val(int b, int i);
        return {8'(b + 1), 24'(5 * i + 1)};
    endfunction

    // Monitor: read data is due one edge after the sampled strobe.
    always @(posedge clk) rd_pend <= reg_rd;

    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: read with no expected item, got %h expected none", reg_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (reg_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_exp(input logic [3:0] a, input logic [31:0] e, input string tag);
        reg_rd = 1'b1; reg_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // One iteration: stream b sends IL beats starting lat_base+b cycles after iter_start.
    task automatic run_iter(input int lat_base, input bit corrupt);
        iter_start = 1'b1;
        @(negedge clk);
        iter_start = 1'b0;
        for (int k = 1; k <= lat_base + NB + IL; k++) begin
            for (int b = 0; b < NB; b++) begin
                int ix;
                ix = k - (lat_base + b);
                mon_valid[b] = (ix >= 0) && (ix < IL);
                mon_data[b*32 +: 32] = ref_val(b, ix);
                if (corrupt && b == 2 && (ix == 5 || ix == 9))
                    mon_data[b*32 +: 32] = ref_val(b, ix) ^ 32'h1;
            end
            @(negedge clk);
        end
        mon_valid = '0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        rd_exp(4'd0, 32'd0, "R11 ctrl after reset");
        rd_exp(4'd1, 32'd0, "R11 output count after reset");
        rd_exp(4'd8, 32'd0, "R11 throughput after reset");
        rd_exp(4'd5, 32'd0, "R11 first latency after reset");

        test_on = 1'b1;
        repeat (2) @(negedge clk);

        run_iter(3, 1'b0);
        run_iter(6, 1'b1);
        run_iter(4, 1'b0);
        repeat (2) @(negedge clk);

        for (int b = 0; b < NB; b++) begin
            wr_reg(4'd0, 32'(b));
            rd_exp(4'd0, 32'(b), "R8 select readback");
            rd_exp(4'd1, 32'd48, "R2 output count");
            rd_exp(4'd2, 32'd0, "R4 output high half");
            rd_exp(4'd3, (b == 2) ? 32'd2 : 32'd0, (b == 2) ? "R3 mismatch count" : "R1 aligned compare over wraps");
            rd_exp(4'd4, 32'd0, "R4 mismatch high half");
            rd_exp(4'd5, 32'(3 + b), "R5 first-run latency");
            rd_exp(4'd6, 32'(4 + b), "R6 later min latency");
            rd_exp(4'd7, 32'(6 + b), "R6 later max latency");
        end
        rd_exp(4'd12, 32'd0, "R8 unused address");

        // Traffic while off is ignored
        wr_reg(4'd0, 32'd0);
        test_on = 1'b0;
        @(negedge clk);
        iter_start = 1'b1;
        mon_valid = '1;
        mon_data = '0;
        repeat (4) @(negedge clk);
        iter_start = 1'b0;
        mon_valid = '0;
        rd_exp(4'd1, 32'd48, "R2 beats ignored while off");
        wr_reg(4'd0, 32'd2);
        rd_exp(4'd3, 32'd2, "R3 mismatches ignored while off");

        // Restart clears statistics, keeps select
        test_on = 1'b1;
        repeat (2) @(negedge clk);
        rd_exp(4'd0, 32'd2, "R10 select kept over restart");
        rd_exp(4'd1, 32'd0, "R10 output count cleared");
        rd_exp(4'd3, 32'd0, "R10 mismatch count cleared");
        rd_exp(4'd5, 32'd0, "R10 first latency cleared");
        rd_exp(4'd6, 32'd0, "R10 min latency cleared");
        rd_exp(4'd7, 32'd0, "R10 max latency cleared");

        // Throughput: stream b valid every 2^b cycles
        for (int c = 0; c < 3 * W + 12; c++) begin
            int s;
            for (int b = 0; b < NB; b++) begin
                mon_valid[b] = ((c % (1 << b)) == 0);
                mon_data[b*32 +: 32] = 32'(c);
            end
            reg_wr = 1'b0;
            reg_rd = 1'b0;
            s = c - 3 * W;
            if (s >= 0 && s < 2 * NB) begin
                if ((s % 2) == 0) begin
                    reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'(s / 2);
                end else begin
                    reg_rd = 1'b1; reg_addr = 4'd8;
                    exp_q.push_back(32'(W >> (s / 2)));
                    tag_q.push_back("R7 beats per window");
                end
            end
            @(negedge clk);
        end
        reg_wr = 1'b0;
        reg_rd = 1'b0;
        mon_valid = '0;
        repeat (4) @(negedge clk);

        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: got %0d pending reads expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule